// File: doc/BRIEF.md
# I2C Master Interrupt Status and Start Control

This block is the interrupt front end of an I2C master. The bus engine reports four kinds of single-cycle event: a finished transaction, an acknowledge error on address or data, a refused high-speed master code, and the end of one transfer inside a chained multi-transfer sequence. Each event sets a sticky status bit. A mask register chooses which pending bits reach a single level-sensitive interrupt line. Software clears status bits by writing ones.

The same 16-bit register port holds a start register. Writing it sends a one-cycle launch pulse and a one-cycle chain-trigger pulse to the bus engine, and stores a chain-configure level. An acknowledge error is always reported in two steps: the error bit first, then the completion bit one cycle later, so that an interrupt handler that ORs status into a software copy collects both. While a transfer-end event is pending, a start write carrying launch, trigger and configure together re-launches the chain and retires that pending bit in the same step.

No data flows through the block, so it has no valid/ready stream interface. Every pin is a plain control or status signal: writes complete in the cycle `wr_en_i` is high, and reads are combinational and have no side effect.

Top module: `i2c_irq_status_ctrl`

## Requirements
- R1: After reset the status, mask and stored configure level are zero, `irq_o`, `start_o`, `mtrig_o` and `mcfg_o` are low, and every address reads 0.
- R2: A pulse on `ev_done_i`, `ev_ackerr_i`, `ev_hsnack_i` or `ev_rsdone_i` sets status bit 0, 1, 2 or 4 (address 0) at the next clock edge. The bit then stays set until it is cleared. Status bit 3 and bits 5 to 15 always read 0.
- R3: A write to address 0 clears every status bit whose data bit is 1 and leaves every status bit whose data bit is 0 unchanged.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit is set after the edge.
- R5: A pulse on `ev_ackerr_i` sets status bit 1 at the next edge and status bit 0 at the edge after that, without any completion event from the engine.
- R6: The mask register at address 1 stores bits 0, 1, 2 and 4 of the written data at the same positions as the status bits. All other mask bits read 0.
- R7: `irq_o` is high in the cycle after a cycle in which some status bit and its mask bit are both 1. It is low in the cycle after a cycle in which no such pair exists.
- R8: A write to address 2 with bit 0 set drives `start_o` high for exactly the next cycle. Data bit 14 does the same for `mtrig_o`. Data bit 15 is stored, drives `mcfg_o`, and reads back at bit 15 of address 2. Bits 0 and 14 of address 2 read 0.
- R9: A write to address 2 with bits 15, 14 and 0 all set, made while status bit 4 is set, clears status bit 4 at that edge unless `ev_rsdone_i` is high in the same cycle. The same write pulses `start_o` and `mtrig_o` as in R8.
- R10: Address 3 reads 0, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_done_i | input | 1 | Transaction-complete event pulse |
| ev_ackerr_i | input | 1 | Acknowledge-error event pulse |
| ev_hsnack_i | input | 1 | High-speed master-code refusal pulse |
| ev_rsdone_i | input | 1 | Chained-transfer end event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (2) | Write address: 0 status, 1 mask, 2 start |
| wr_data_i | input | DATA_W (16) | Write data |
| rd_addr_i | input | ADDR_W (2) | Read address |
| rd_data_o | output | DATA_W (16) | Combinational read data |
| irq_o | output | 1 | Registered level interrupt |
| start_o | output | 1 | One-cycle launch pulse |
| mtrig_o | output | 1 | One-cycle chain-trigger pulse |
| mcfg_o | output | 1 | Stored chain-configure level |

## Verification
The hardest cases to reach are the collisions. A chain re-launch must land in exactly the cycle in which a new transfer-end event arrives. A clearing write must meet the delayed completion bit that an acknowledge error schedules one cycle after its own event. The stimulus makes these collisions by putting the event pulse and the register write into the same cycle, and by issuing a clear one cycle after an acknowledge-error pulse. A behavioural model updated on every edge predicts the outcome. The read address steps through all four addresses on every cycle, so all registers are compared cycle by cycle alongside the four output pins.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  // status / mask layout, decoded by software
  localparam int ST_W   = 5;
  localparam int B_DONE = 0;
  localparam int B_ACK  = 1;
  localparam int B_HSN  = 2;
  localparam int B_RS   = 4;
  localparam logic [ST_W-1:0] IMPL_MASK = 5'b10111;

  // start register layout
  localparam int SP_GO   = 0;
  localparam int SP_TRIG = 14;
  localparam int SP_CFG  = 15;

  // register addresses
  localparam int A_STAT  = 0;
  localparam int A_MASK  = 1;
  localparam int A_START = 2;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_o[g] <= 1'b0;
      else if (set_i[g])   q_o[g] <= 1'b1;
      else if (clr_i[g])   q_o[g] <= 1'b0;
    end

    AST_EVT_SETS:   assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_i[g]) |-> q_o[g]);                          // R2
    AST_STICKY:     assert property (@(posedge clk) disable iff (!rst_n)
      ($past(q_o[g]) && !$past(clr_i[g])) |-> q_o[g]);      // R3
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_i[g] && clr_i[g]) |-> q_o[g]);              // R4
  end
endmodule

// File: rtl/irq_start_gen.sv
module irq_start_gen
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              go_o,
  output logic              trig_o,
  output logic              cfg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_o   <= 1'b0;
      trig_o <= 1'b0;
      cfg_o  <= 1'b0;
    end else begin
      go_o   <= wr_i & data_i[SP_GO];
      trig_o <= wr_i & data_i[SP_TRIG];
      if (wr_i) cfg_o <= data_i[SP_CFG];
    end
  end

  AST_GO_ONE_CYCLE:   assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && !$past(wr_i)) |-> 1'b0);                       // R8
  AST_TRIG_SELF_CLR:  assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_i) |-> !trig_o);                              // R8
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(stat_i & mask_i);
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_i & mask_i)) |=> irq_o);                        // R7
  AST_IRQ_DROP:  assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_i & mask_i)) |=> !irq_o);                      // R7
endmodule

// File: rtl/i2c_irq_status_ctrl.sv
module i2c_irq_status_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_done_i,
  input  logic              ev_ackerr_i,
  input  logic              ev_hsnack_i,
  input  logic              ev_rsdone_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              start_o,
  output logic              mtrig_o,
  output logic              mcfg_o
);
  localparam int PAD_W = DATA_W - ST_W;

  logic            wr_stat, wr_mask, wr_start;
  logic            ack_pend;
  logic            rearm;
  logic [ST_W-1:0] status, mask, set_v, clr_v;

  assign wr_stat  = wr_en_i && (wr_addr_i == ADDR_W'(A_STAT));
  assign wr_mask  = wr_en_i && (wr_addr_i == ADDR_W'(A_MASK));
  assign wr_start = wr_en_i && (wr_addr_i == ADDR_W'(A_START));

  // chain re-launch: all three start qualifiers while a transfer end is pending
  assign rearm = wr_start && wr_data_i[SP_GO] && wr_data_i[SP_TRIG]
                 && wr_data_i[SP_CFG] && status[B_RS];

  // acknowledge error posts completion one cycle behind the error bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_pend <= 1'b0;
    else        ack_pend <= ev_ackerr_i;
  end

  always_comb begin
    set_v         = '0;
    set_v[B_DONE] = ev_done_i | ack_pend;
    set_v[B_ACK]  = ev_ackerr_i;
    set_v[B_HSN]  = ev_hsnack_i;
    set_v[B_RS]   = ev_rsdone_i;
    clr_v         = wr_stat ? (wr_data_i[ST_W-1:0] & IMPL_MASK) : '0;
    if (rearm) clr_v[B_RS] = 1'b1;
  end

  irq_sticky_bank #(.W(ST_W)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .q_o   (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (wr_mask) mask <= wr_data_i[ST_W-1:0] & IMPL_MASK;
  end

  irq_line #(.W(ST_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (status),
    .mask_i (mask),
    .irq_o  (irq_o)
  );

  irq_start_gen #(.DATA_W(DATA_W)) u_start (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_start),
    .data_i (wr_data_i),
    .go_o   (start_o),
    .trig_o (mtrig_o),
    .cfg_o  (mcfg_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_W'(A_STAT):  rd_data_o = {{PAD_W{1'b0}}, status};
      ADDR_W'(A_MASK):  rd_data_o = {{PAD_W{1'b0}}, mask};
      ADDR_W'(A_START): rd_data_o[SP_CFG] = mcfg_o;
      default:          rd_data_o = '0;
    endcase
  end

  AST_ACK_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ackerr_i |=> ##1 status[B_DONE]);                    // R5
  AST_REARM_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !ev_rsdone_i) |=> !status[B_RS]);             // R9
  AST_REARM_LAUNCH:  assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (start_o && mtrig_o && mcfg_o));              // R9
  AST_GAP_BIT_ZERO:  assert property (@(posedge clk) disable iff (!rst_n)
    !status[3] && !mask[3]);                                // R2
endmodule

// File: tb/sim_i2c_irq_status_ctrl.sv
module sim_i2c_irq_status_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        ev_done = 0, ev_ack = 0, ev_hs = 0, ev_rs = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        irq, go, trig, cfg;

  always #5 clk = ~clk;

  i2c_irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_done_i(ev_done), .ev_ackerr_i(ev_ack), .ev_hsnack_i(ev_hs), .ev_rsdone_i(ev_rs),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .start_o(go), .mtrig_o(trig), .mcfg_o(cfg)
  );

  int errors = 0, checks = 0;
  string phase = "R1";
  bit finished = 0;

  // behavioural reference model
  int m_stat = 0, m_mask = 0, m_irq = 0, m_go = 0, m_trig = 0, m_cfg = 0, m_ackq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_irq = 0; m_go = 0; m_trig = 0; m_cfg = 0; m_ackq = 0;
    end else begin
      int clr, setv, nstat;
      clr = (wr_en && wr_addr == 0) ? (wr_data & 'h17) : 0;
      if (wr_en && wr_addr == 2 && (wr_data & 'hC001) == 'hC001 && (m_stat & 'h10) != 0)
        clr = clr | 'h10;
      setv = (ev_done || m_ackq ? 1 : 0) | (ev_ack ? 2 : 0) | (ev_hs ? 4 : 0) | (ev_rs ? 16 : 0);
      nstat = setv | (m_stat & ~clr);
      m_irq = ((m_stat & m_mask) != 0) ? 1 : 0;
      if (wr_en && wr_addr == 1) m_mask = wr_data & 'h17;
      m_go   = (wr_en && wr_addr == 2 && wr_data[0])  ? 1 : 0;
      m_trig = (wr_en && wr_addr == 2 && wr_data[14]) ? 1 : 0;
      if (wr_en && wr_addr == 2) m_cfg = wr_data[15];
      m_ackq = ev_ack;
      m_stat = nstat;
    end
  end

  function automatic int model_read(int a);
    case (a)
      0: return m_stat;
      1: return m_mask;
      2: return m_cfg << 15;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({phase, " irq"},   irq,  m_irq);
      chk({phase, " start"}, go,   m_go);
      chk({phase, " trig"},  trig, m_trig);
      chk({phase, " cfg"},   cfg,  m_cfg);
      chk({phase, " read"},  rd_data, model_read(rd_addr));
    end
  end

  task automatic step();
    @(posedge clk); #1;
    rd_addr = rd_addr + 1;
    ev_done = 0; ev_ack = 0; ev_hs = 0; ev_rs = 0; wr_en = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = a[1:0]; wr_data = d[15:0];
    step();
  endtask

  task automatic read_now(string tag, int a, int exp);
    rd_addr = a[1:0]; #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    chk("R1 irq during reset", irq, 0);
    chk("R1 start during reset", go, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    read_now("R1 status", 0, 0);
    read_now("R1 mask", 1, 0);
    read_now("R1 start", 2, 0);
    chk("R1 cfg", cfg, 0);
    idle(4);

    phase = "R6";
    wr(1, 'hFFFF);
    read_now("R6 mask readback", 1, 'h17);
    wr(1, 'h0017);

    phase = "R2";
    ev_done = 1; step();
    read_now("R2 done bit", 0, 1);
    idle(3);
    ev_hs = 1; step();
    ev_rs = 1; step();
    read_now("R2 hs+rs bits", 0, 'h15);
    idle(2);

    phase = "R3";
    wr(0, 'h0000);
    read_now("R3 zero write keeps", 0, 'h15);
    wr(0, 'h0004);
    read_now("R3 clear hs only", 0, 'h11);
    wr(0, 'hFFFF);
    read_now("R3 clear all", 0, 0);
    idle(2);

    phase = "R7";
    wr(1, 'h0004);
    ev_done = 1; step();
    idle(2);
    chk("R7 masked source no irq", irq, 0);
    ev_hs = 1; step();
    idle(1);
    chk("R7 enabled source irq", irq, 1);
    wr(0, 'h0004);
    idle(1);
    chk("R7 irq drops after clear", irq, 0);
    wr(0, 'h0001);
    wr(1, 'h0017);

    phase = "R4";
    ev_hs = 1; wr(0, 'h0004);
    read_now("R4 event beats clear", 0, 'h04);
    wr(0, 'h0004);
    idle(2);

    phase = "R5";
    ev_ack = 1; step();
    read_now("R5 error first", 0, 'h02);
    step();
    read_now("R5 done follows", 0, 'h03);
    wr(0, 'h0003);
    ev_ack = 1; step();
    wr(0, 'h0001);
    read_now("R5 delayed done beats clear", 0, 'h03);
    wr(0, 'h0003);
    idle(3);

    phase = "R8";
    wr(2, 'h0001);
    idle(2);
    wr(2, 'h4000);
    idle(2);
    wr(2, 'h8000);
    read_now("R8 cfg readback", 2, 'h8000);
    chk("R8 cfg level", cfg, 1);
    wr(2, 'hC001);
    read_now("R8 no rearm without pending", 0, 0);
    wr(2, 'h0000);
    idle(2);

    phase = "R9";
    ev_rs = 1; step();
    wr(2, 'h4001);
    read_now("R9 partial start keeps pending", 0, 'h10);
    wr(2, 'hC001);
    read_now("R9 rearm clears pending", 0, 0);
    ev_rs = 1; step();
    ev_rs = 1; wr(2, 'hC001);
    read_now("R9 new event wins over rearm", 0, 'h10);
    wr(0, 'h0010);
    wr(2, 'h0000);
    idle(2);

    phase = "R10";
    ev_hs = 1; step();
    wr(3, 'hFFFF);
    read_now("R10 addr3 reads zero", 3, 0);
    read_now("R10 status untouched", 0, 'h04);
    read_now("R10 mask untouched", 1, 'h17);
    wr(0, 'h0004);
    idle(4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule